// File: doc/BRIEF.md
# Flash Program/Erase Status Timer

This block runs the internally timed part of a flash write once a command decoder has accepted a program or erase request. It captures the operation type, the target address and the write data in the cycle it is started. It then holds a busy flag for a fixed number of clock cycles and needs no further bus activity to finish.

While the operation runs, any read aimed at the busy bank gets a synthetic status byte instead of array data. Bit 7 is the polling bit. For a program it carries the inverse of the written byte's top bit, and for an erase it reads 0. Bit 6 is a toggle bit that changes after each read strobe. When the time runs out, the block gives a single-cycle completion pulse. In that same cycle it presents the captured operation, address and data as an update request to the array, which lives outside this block.

Each duration is a separate cycle-count parameter, so simulation can shrink the counts to a few cycles while real builds use counts that match microseconds or milliseconds.

Top module: `wop_status_timer`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `upd_o` are 0 and `status_o` is 8'h00.
- R2: A start pulse accepted while idle raises `busy_o` in the following cycle. The flag stays high for exactly PROG_CYC cycles for op code 0 (byte program), SECT_CYC cycles for op code 1 (sector erase) or BANK_CYC cycles for op code 2 (bank erase).
- R3: `done_o` is high for exactly one cycle: the first cycle in which `busy_o` is low after an operation. `upd_o` is high in that same cycle only.
- R4: While a program is busy, `status_o[7]` equals the inverse of bit 7 of the captured data byte.
- R5: While an erase (op code 1 or 2) is busy, `status_o[7]` is 0.
- R6: `status_o[6]` is 0 in the first busy cycle of every operation. It inverts after each cycle in which `rd_i` is high while busy, and holds its value in every other busy cycle.
- R7: While busy, `status_o[5:0]` is 0. While idle, all of `status_o` is 0.
- R8: A start pulse while busy is ignored. The running operation keeps its duration, and its captured address and data are unchanged at completion.
- R9: A start pulse with op code 3 is ignored, and `busy_o` stays low.
- R10: In the cycle `upd_o` is high, `upd_op_o`, `upd_addr_o` and `upd_data_o` carry the op code, address and data captured at the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to begin an operation |
| op_i | input | 2 | Operation code: 0 program, 1 sector erase, 2 bank erase, 3 reserved |
| addr_i | input | ADDR_W | Target address captured at start |
| data_i | input | 8 | Program data captured at start |
| rd_i | input | 1 | Read strobe from the busy bank, one cycle per read |
| busy_o | output | 1 | Operation in progress |
| status_o | output | 8 | Status byte returned in place of array data while busy |
| done_o | output | 1 | One-cycle completion pulse |
| upd_o | output | 1 | Array update request, coincident with done_o |
| upd_op_o | output | 2 | Captured operation code for the update |
| upd_addr_o | output | ADDR_W | Captured address for the update |
| upd_data_o | output | 8 | Captured data for the update |

## Verification
The assertions assume three things about the inputs. `start_i` and `rd_i` are synchronous single-cycle strobes. Every duration parameter is at least 1. Reset is held for at least one edge before the first start. The stimulus drives every strobe for exactly one cycle on the falling clock edge and keeps the durations at small positive values. Reads and extra start pulses during an operation are drawn at random, so the checks see both back-to-back and sparse reads, as well as starts that collide with a running operation.

// File: rtl/wop_pkg.sv
package wop_pkg;
  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_BANK = 2'd2,
    OP_RSVD = 2'd3
  } op_e;

  function automatic logic op_is_erase(logic [1:0] op);
    return (op == OP_SECT) || (op == OP_BANK);
  endfunction

  function automatic logic op_is_legal(logic [1:0] op);
    return op != OP_RSVD;
  endfunction
endpackage

// File: rtl/wop_timer.sv
module wop_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             done_q;

  assign expire_o = busy_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= expire_o;
      if (load_i && !busy_q) begin
        busy_q <= 1'b1;
        cnt_q  <= load_val_i;
      end else if (expire_o) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  // R2: the countdown moves by one each busy cycle until it expires
  assert_count_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1));

  // R3: expiry ends busy and produces the completion pulse on the next cycle
  assert_expire_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> (done_q && !busy_q));
endmodule

// File: rtl/wop_toggle.sv
module wop_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic step_i,
  output logic tog_o
);
  logic tog_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       tog_q <= 1'b0;
    else if (clear_i) tog_q <= 1'b0;
    else if (step_i)  tog_q <= ~tog_q;
  end

  assign tog_o = tog_q;

  // R6: without a read step or a clear the toggle bit holds
  assert_toggle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !clear_i) |=> $stable(tog_q));

  // R6: a clear leaves the toggle bit at zero
  assert_toggle_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !tog_q);
endmodule

// File: rtl/wop_status.sv
module wop_status
  import wop_pkg::*;
(
  input  logic       busy_i,
  input  logic [1:0] op_i,
  input  logic       data7_i,
  input  logic       tog_i,
  output logic [7:0] status_o
);
  function automatic logic poll_bit(logic [1:0] op, logic d7);
    return op_is_erase(op) ? 1'b0 : ~d7;
  endfunction

  always_comb begin
    status_o = 8'h00;
    if (busy_i) begin
      status_o[7] = poll_bit(op_i, data7_i);
      status_o[6] = tog_i;
    end
  end
endmodule

// File: rtl/wop_status_timer.sv
module wop_status_timer
  import wop_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int PROG_CYC = 2000,
  parameter int SECT_CYC = 1800000,
  parameter int BANK_CYC = 7000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic              rd_i,
  output logic              busy_o,
  output logic [7:0]        status_o,
  output logic              done_o,
  output logic              upd_o,
  output logic [1:0]        upd_op_o,
  output logic [ADDR_W-1:0] upd_addr_o,
  output logic [7:0]        upd_data_o
);
  localparam int MAX_A  = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
  localparam int MAX_C  = (MAX_A > BANK_CYC) ? MAX_A : BANK_CYC;
  localparam int CNT_W  = $clog2(MAX_C + 1);

  function automatic logic [CNT_W-1:0] reload_of(logic [1:0] op);
    case (op)
      OP_SECT: return CNT_W'(SECT_CYC - 1);
      OP_BANK: return CNT_W'(BANK_CYC - 1);
      default: return CNT_W'(PROG_CYC - 1);
    endcase
  endfunction

  logic              accept;
  logic              busy;
  logic              expire;
  logic              rd_step;
  logic              tog;
  logic [1:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;

  assign accept  = start_i && !busy && op_is_legal(op_i);
  assign rd_step = rd_i && busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= OP_PROG;
      addr_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      op_q   <= op_i;
      addr_q <= addr_i;
      data_q <= data_i;
    end
  end

  wop_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (accept),
    .load_val_i (reload_of(op_i)),
    .busy_o     (busy),
    .done_o     (done_o),
    .expire_o   (expire)
  );

  wop_toggle u_toggle (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (accept),
    .step_i  (rd_step),
    .tog_o   (tog)
  );

  wop_status u_status (
    .busy_i   (busy),
    .op_i     (op_q),
    .data7_i  (data_q[7]),
    .tog_i    (tog),
    .status_o (status_o)
  );

  assign busy_o     = busy;
  assign upd_o      = done_o;
  assign upd_op_o   = op_q;
  assign upd_addr_o = addr_q;
  assign upd_data_o = data_q;

  // R2: busy only rises after a legal start pulse
  assert_busy_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ($past(start_i) && $past(op_i) != OP_RSVD));

  // R3: the completion pulse lasts one cycle and follows a busy cycle
  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o))) ;
  assert_done_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8: captured operands hold while busy
  assert_capture_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !expire) |=> ($stable(addr_q) && $stable(data_q) && $stable(op_q)));

  // R9: a reserved op code never starts an operation
  assert_rsvd_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && op_i == OP_RSVD) |=> !busy_o);

  // R7: the idle status byte is all zero
  assert_idle_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> status_o == 8'h00);
endmodule

// File: tb/wop_status_timer_test.sv
module wop_status_timer_test;
  localparam int ADDR_W = 18;
  localparam int PC = 5;
  localparam int SC = 9;
  localparam int BC = 14;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [1:0]        op_i = 2'd0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [7:0]        data_i = '0;
  logic              rd_i = 1'b0;
  logic              busy_o;
  logic [7:0]        status_o;
  logic              done_o;
  logic              upd_o;
  logic [1:0]        upd_op_o;
  logic [ADDR_W-1:0] upd_addr_o;
  logic [7:0]        upd_data_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  wop_status_timer #(.ADDR_W(ADDR_W), .PROG_CYC(PC), .SECT_CYC(SC), .BANK_CYC(BC)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .addr_i(addr_i),
    .data_i(data_i), .rd_i(rd_i), .busy_o(busy_o), .status_o(status_o),
    .done_o(done_o), .upd_o(upd_o), .upd_op_o(upd_op_o), .upd_addr_o(upd_addr_o),
    .upd_data_o(upd_data_o));

  function automatic int dur(logic [1:0] op);
    if (op == 2'd1) return SC;
    if (op == 2'd2) return BC;
    return PC;
  endfunction

  function automatic logic [7:0] exp_status(logic [1:0] op, logic [7:0] d, bit t);
    logic [7:0] s;
    s = 8'h00;
    s[7] = (op == 2'd0) ? !d[7] : 1'b0;
    s[6] = t;
    return s;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Runs one operation; rd_pct is the read percentage, coll asks for a colliding start
  task automatic run_op(logic [1:0] op, logic [ADDR_W-1:0] a, logic [7:0] d,
                        int rd_pct, bit coll);
    int n;
    bit t;
    n = dur(op);
    t = 1'b0;
    @(negedge clk);
    start_i = 1'b1; op_i = op; addr_i = a; data_i = d;
    for (int k = 1; k <= n + 2; k++) begin
      @(negedge clk);
      start_i = 1'b0; rd_i = 1'b0;
      chk((k <= n) ? "R2 busy" : "R2 busy low", {31'd0, busy_o}, {31'd0, (k <= n)});
      chk("R3 done", {31'd0, done_o}, {31'd0, (k == n + 1)});
      chk("R3 upd", {31'd0, upd_o}, {31'd0, (k == n + 1)});
      if (k <= n) begin
        if (op == 2'd0) chk("R4 poll", {31'd0, status_o[7]}, {31'd0, !d[7]});
        else            chk("R5 poll", {31'd0, status_o[7]}, 32'd0);
        chk("R6 toggle", {31'd0, status_o[6]}, {31'd0, t});
        chk("R7 low bits", {26'd0, status_o[5:0]}, 32'd0);
        if (($urandom % 100) < rd_pct) begin
          rd_i = 1'b1;
          t = !t;
        end
        if (coll && k == 2) begin
          start_i = 1'b1; op_i = 2'd2; addr_i = ~a; data_i = ~d;
        end
      end else begin
        chk("R7 idle status", {24'd0, status_o}, 32'd0);
      end
      if (k == n + 1) begin
        chk(coll ? "R8 addr" : "R10 addr", {14'd0, upd_addr_o}, {14'd0, a});
        chk(coll ? "R8 data" : "R10 data", {24'd0, upd_data_o}, {24'd0, d});
        chk("R10 op", {30'd0, upd_op_o}, {30'd0, op});
      end
    end
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", {31'd0, busy_o}, 32'd0);
    chk("R1 done", {31'd0, done_o}, 32'd0);
    chk("R1 upd", {31'd0, upd_o}, 32'd0);
    chk("R1 status", {24'd0, status_o}, 32'd0);

    // directed: each op type, every-cycle reads and no reads
    run_op(2'd0, 18'h15555, 8'h3C, 100, 1'b0);
    run_op(2'd0, 18'h00001, 8'hA5, 0, 1'b0);
    run_op(2'd1, 18'h3F000, 8'h30, 100, 1'b0);
    run_op(2'd2, 18'h05555, 8'h10, 50, 1'b0);
    // R8: start while busy must be ignored
    run_op(2'd0, 18'h12345, 8'h80, 50, 1'b1);
    run_op(2'd1, 18'h2A000, 8'h7F, 30, 1'b1);

    // R9: reserved op code
    @(negedge clk);
    start_i = 1'b1; op_i = 2'd3; addr_i = 18'h1; data_i = 8'h55;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk("R9 rsvd busy", {31'd0, busy_o}, 32'd0);
      chk("R9 rsvd status", {24'd0, status_o}, 32'd0);
      @(negedge clk);
    end

    // constrained random: legal ops only, random read density
    for (int i = 0; i < 40; i++) begin
      run_op(2'($urandom % 3), ADDR_W'($urandom), 8'($urandom),
             int'($urandom % 101), bit'($urandom % 4 == 0));
      repeat ($urandom % 3) @(negedge clk);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule